// File: doc/BRIEF.md
# NAND Flash Write Strobe Generator

This block produces the write-side bus cycles of an 8-bit NAND flash port. A host loads a timing word and a control word through a small register write port. It then requests a command, address or data cycle together with the byte to send. The block raises the matching latch-enable line and drives the byte. After a programmed setup time it pulls the write strobe low for a programmed width. It holds the byte for a programmed time after the strobe rises, then releases the bus and pulses `done`.

Each of the three phase lengths is stored as its cycle count minus one, so a field value N lasts N+1 clocks. The setup field is 2 bits wide, for 1 to 4 clocks. The strobe-width and hold fields are 3 bits each, for 1 to 8 clocks. The timing fields are copied when a cycle starts, so rewriting them while a cycle runs only affects later cycles. The chip-select output simply follows a control bit.

Top module: `nand_strobe_gen`

## Requirements
- R1: After reset, all three timing fields are at their maximum (setup 3, width 7, hold 7), the controller is disabled, and chip select is high. The bus is idle: both latch lines low, write strobe high, drive enable low, `busy` and `done` low. A cycle started after enabling, without writing the timing word, lasts 4 + 8 + 8 clocks.
- R2: The setup phase lasts setup+1 clocks. During it the write strobe is high while the latch line, drive enable and byte are valid.
- R3: The write strobe is low for exactly width+1 consecutive clocks, and only while the bus is driven.
- R4: After the strobe rises, the byte, drive enable and latch line stay unchanged for hold+1 clocks. All of them are released together when the hold phase ends.
- R5: The cycle kind is `startKind`. 2'b01 is a command (only `cmdLatch` high), 2'b10 is an address (only `addrLatch` high), and 2'b00 or 2'b11 is data (neither high). The two latch lines are never high together.
- R6: `done` is high for exactly one clock: the first clock after the hold phase, in which the bus is already released.
- R7: A start request made while a cycle is in progress is ignored. The running cycle keeps its byte, kind and timing, and no extra cycle follows.
- R8: A start request is ignored while the enable bit (control bit 0) is 0.
- R9: `chipSelN` equals control bit 1 on the clock after the register write, so writing 0 selects the chip.
- R10: The timing word (`regSel`=0) is laid out as bits [1:0] setup, [4:2] width and [7:5] hold. It is sampled when a cycle is accepted, so a write during a cycle changes only the following cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 1 | 0 = timing word, 1 = control word (bit 0 enable, bit 1 chip-select level) |
| regWrData | input | 8 | Register write data |
| startReq | input | 1 | Request one bus cycle |
| startKind | input | 2 | Cycle kind: 00 data, 01 command, 10 address, 11 data |
| startByte | input | 8 | Byte to place on the bus |
| busy | output | 1 | A cycle is in progress |
| done | output | 1 | One-clock pulse after a cycle ends |
| cmdLatch | output | 1 | Command latch enable to the flash |
| addrLatch | output | 1 | Address latch enable to the flash |
| writeStrobeN | output | 1 | Write strobe, active low |
| chipSelN | output | 1 | Chip select, active low |
| busDriveEn | output | 1 | Data bus output enable |
| busData | output | 8 | Data bus value (zero when not driven) |

## Verification
The bench measures every phase in clocks and compares it with field+1, at both extremes. All-zero fields catch a design that drops the added clock or merges phases. The reset maximums catch a field that wraps or is truncated. A timing write in the middle of a cycle shows whether the design reads the fields live instead of sampling them, and the phase lengths would then change mid-cycle. Start requests sent while busy or disabled show whether the design restarts or corrupts the byte, or issues a cycle that nobody queued. Reserved kind 11, chip-select toggling, and a `done` pulse that is late, long or early are also checked.

// File: rtl/nand_strobe_pkg.sv
package nand_strobe_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACTIVE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    KIND_DATA = 2'b00,
    KIND_CMD  = 2'b01,
    KIND_ADDR = 2'b10,
    KIND_RSVD = 2'b11
  } kind_e;

  // Control-to-datapath strobes
  typedef struct packed {
    logic   capture;     // accept request: snapshot fields, load setup count
    logic   loadActive;  // load strobe-width count
    logic   loadHold;    // load hold count
    logic   countDown;   // decrement phase counter
    phase_e phase;       // current phase
  } strobe_t;

endpackage

// File: rtl/nand_strobe_path.sv
module nand_strobe_path
  import nand_strobe_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int SETUP_W  = 2,
  parameter int ACTIVE_W = 3,
  parameter int HOLD_W   = 3
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                regWrEn,
  input  logic                                regSel,
  input  logic [SETUP_W+ACTIVE_W+HOLD_W-1:0] regWrData,
  input  logic [1:0]                          startKind,
  input  logic [DATA_W-1:0]                   startByte,
  input  strobe_t                             str,
  output logic                                cntZero,
  output logic                                ctrlEnable,
  output logic                                cmdLatch,
  output logic                                addrLatch,
  output logic                                writeStrobeN,
  output logic                                chipSelN,
  output logic                                busDriveEn,
  output logic [DATA_W-1:0]                   busData
);

  localparam int CFG_W = SETUP_W + ACTIVE_W + HOLD_W;
  localparam int MAX_AH = (ACTIVE_W > HOLD_W) ? ACTIVE_W : HOLD_W;
  localparam int CNT_W = (SETUP_W > MAX_AH) ? SETUP_W : MAX_AH;
  localparam int ACT_LSB = SETUP_W;
  localparam int HOLD_LSB = SETUP_W + ACTIVE_W;

  typedef logic [CNT_W-1:0] cnt_t;

  logic [CFG_W-1:0]    cfgWord;
  logic                csLevel;
  logic [ACTIVE_W-1:0] snapActive;
  logic [HOLD_W-1:0]   snapHold;
  logic [DATA_W-1:0]   snapByte;
  kind_e               snapKind;
  cnt_t                phaseCnt;

  // Register write port
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgWord    <= '1;
      ctrlEnable <= 1'b0;
      csLevel    <= 1'b1;
    end else if (regWrEn) begin
      if (regSel) begin
        ctrlEnable <= regWrData[0];
        csLevel    <= regWrData[1];
      end else begin
        cfgWord <= regWrData;
      end
    end
  end

  // Per-cycle snapshot
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      snapActive <= '0;
      snapHold   <= '0;
      snapByte   <= '0;
      snapKind   <= KIND_DATA;
    end else if (str.capture) begin
      snapActive <= cfgWord[ACT_LSB +: ACTIVE_W];
      snapHold   <= cfgWord[HOLD_LSB +: HOLD_W];
      snapByte   <= startByte;
      snapKind   <= kind_e'(startKind);
    end
  end

  // Shared phase counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= '0;
    end else if (str.capture) begin
      phaseCnt <= cnt_t'(cfgWord[SETUP_W-1:0]);
    end else if (str.loadActive) begin
      phaseCnt <= cnt_t'(snapActive);
    end else if (str.loadHold) begin
      phaseCnt <= cnt_t'(snapHold);
    end else if (str.countDown) begin
      phaseCnt <= phaseCnt - cnt_t'(1);
    end
  end

  assign cntZero = (phaseCnt == '0);

  // Bus decode from the registered phase
  always_comb begin
    busDriveEn   = (str.phase != PH_IDLE);
    writeStrobeN = (str.phase != PH_ACTIVE);
    cmdLatch     = busDriveEn && (snapKind == KIND_CMD);
    addrLatch    = busDriveEn && (snapKind == KIND_ADDR);
    busData      = busDriveEn ? snapByte : '0;
    chipSelN     = csLevel;
  end

  // R7: byte captured for a running cycle is not disturbed
  assert_snap_stable_R7 : assert property (@(posedge clk) disable iff (!rstN)
    (str.phase != PH_IDLE) |=> $stable(snapByte));

  // R2: counter only decremented while non-zero
  assert_no_underflow_R2 : assert property (@(posedge clk) disable iff (!rstN)
    str.countDown |=> (phaseCnt != '1));

endmodule

// File: rtl/nand_strobe_ctrl.sv
module nand_strobe_ctrl
  import nand_strobe_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startReq,
  input  logic    ctrlEnable,
  input  logic    cntZero,
  output strobe_t str,
  output logic    busy,
  output logic    done
);

  phase_e state, nextState;

  always_comb begin
    str       = '0;
    str.phase = state;
    nextState = state;
    unique case (state)
      PH_IDLE: begin
        if (startReq && ctrlEnable) begin
          str.capture = 1'b1;
          nextState   = PH_SETUP;
        end
      end
      PH_SETUP: begin
        if (cntZero) begin
          str.loadActive = 1'b1;
          nextState      = PH_ACTIVE;
        end else begin
          str.countDown = 1'b1;
        end
      end
      PH_ACTIVE: begin
        if (cntZero) begin
          str.loadHold = 1'b1;
          nextState    = PH_HOLD;
        end else begin
          str.countDown = 1'b1;
        end
      end
      PH_HOLD: begin
        if (cntZero) nextState = PH_IDLE;
        else         str.countDown = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= PH_IDLE;
      done  <= 1'b0;
    end else begin
      state <= nextState;
      done  <= (state == PH_HOLD) && cntZero;
    end
  end

  assign busy = (state != PH_IDLE);

  assert_done_pulse_R6 : assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_disabled_idle_R8 : assert property (@(posedge clk) disable iff (!rstN)
    ((state == PH_IDLE) && !ctrlEnable) |=> (state == PH_IDLE));

endmodule

// File: rtl/nand_strobe_gen.sv
module nand_strobe_gen
  import nand_strobe_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int SETUP_W  = 2,
  parameter int ACTIVE_W = 3,
  parameter int HOLD_W   = 3
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                regWrEn,
  input  logic                                regSel,
  input  logic [SETUP_W+ACTIVE_W+HOLD_W-1:0] regWrData,
  input  logic                                startReq,
  input  logic [1:0]                          startKind,
  input  logic [DATA_W-1:0]                   startByte,
  output logic                                busy,
  output logic                                done,
  output logic                                cmdLatch,
  output logic                                addrLatch,
  output logic                                writeStrobeN,
  output logic                                chipSelN,
  output logic                                busDriveEn,
  output logic [DATA_W-1:0]                   busData
);

  strobe_t str;
  logic    cntZero;
  logic    ctrlEnable;

  nand_strobe_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startReq   (startReq),
    .ctrlEnable (ctrlEnable),
    .cntZero    (cntZero),
    .str        (str),
    .busy       (busy),
    .done       (done)
  );

  nand_strobe_path #(
    .DATA_W   (DATA_W),
    .SETUP_W  (SETUP_W),
    .ACTIVE_W (ACTIVE_W),
    .HOLD_W   (HOLD_W)
  ) u_path (
    .clk          (clk),
    .rstN         (rstN),
    .regWrEn      (regWrEn),
    .regSel       (regSel),
    .regWrData    (regWrData),
    .startKind    (startKind),
    .startByte    (startByte),
    .str          (str),
    .cntZero      (cntZero),
    .ctrlEnable   (ctrlEnable),
    .cmdLatch     (cmdLatch),
    .addrLatch    (addrLatch),
    .writeStrobeN (writeStrobeN),
    .chipSelN     (chipSelN),
    .busDriveEn   (busDriveEn),
    .busData      (busData)
  );

  assert_strobe_driven_R3 : assert property (@(posedge clk) disable iff (!rstN)
    !writeStrobeN |-> busDriveEn);

  assert_one_latch_R5 : assert property (@(posedge clk) disable iff (!rstN)
    !(cmdLatch && addrLatch));

  assert_done_released_R6 : assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busDriveEn);

endmodule

// File: tb/nand_strobe_gen_test.sv
module nand_strobe_gen_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic       regSel = 1'b0;
  logic [7:0] regWrData = '0;
  logic       startReq = 1'b0;
  logic [1:0] startKind = '0;
  logic [7:0] startByte = '0;
  logic       busy, done, cmdLatch, addrLatch, writeStrobeN, chipSelN, busDriveEn;
  logic [7:0] busData;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  nand_strobe_gen uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel), .regWrData(regWrData),
    .startReq(startReq), .startKind(startKind), .startByte(startByte),
    .busy(busy), .done(done), .cmdLatch(cmdLatch), .addrLatch(addrLatch),
    .writeStrobeN(writeStrobeN), .chipSelN(chipSelN), .busDriveEn(busDriveEn),
    .busData(busData)
  );

  typedef struct {
    logic [1:0] kind;
    logic [7:0] data;
    int s, w, h;
  } exp_t;

  exp_t expQ[$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic logic [7:0] cfgWord(input int s, input int w, input int h);
    return {3'(h), 3'(w), 2'(s)};
  endfunction

  task automatic writeReg(input logic sel, input logic [7:0] val);
    @(negedge clk);
    regWrEn = 1'b1; regSel = sel; regWrData = val;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic pulseStart(input logic [1:0] k, input logic [7:0] d);
    @(negedge clk);
    startReq = 1'b1; startKind = k; startByte = d;
    @(negedge clk);
    startReq = 1'b0;
  endtask

  task automatic issue(input logic [1:0] k, input logic [7:0] d,
                       input int s, input int w, input int h);
    exp_t e;
    e.kind = k; e.data = d; e.s = s; e.w = w; e.h = h;
    expQ.push_back(e);
    pulseStart(k, d);
  endtask

  task automatic waitIdle();
    do @(negedge clk); while (busy);
  endtask

  // Monitor / scoreboard
  bit inCyc = 0;
  int cs, ca, ch;
  logic [7:0] curByte;
  logic curCmd, curAddr;
  bit glitch;

  task automatic endCycle();
    exp_t e;
    if (expQ.size() == 0) begin
      check(0, "R7", "unexpected bus cycle (R8 if disabled)", 1, 0);
      return;
    end
    e = expQ.pop_front();
    check(cs == e.s + 1, "R2", "setup clocks", cs, e.s + 1);
    check(ca == e.w + 1, "R3", "strobe low clocks", ca, e.w + 1);
    check(ch == e.h + 1, "R4", "hold clocks", ch, e.h + 1);
    check(!glitch, "R4", "bus changed inside cycle", int'(glitch), 0);
    check(curCmd == (e.kind == 2'b01), "R5", "cmdLatch", int'(curCmd), int'(e.kind == 2'b01));
    check(curAddr == (e.kind == 2'b10), "R5", "addrLatch", int'(curAddr), int'(e.kind == 2'b10));
    check(curByte == e.data, "R5", "bus byte", int'(curByte), int'(e.data));
    check(done == 1'b1, "R6", "done at release", int'(done), 1);
  endtask

  initial forever begin
    @(negedge clk);
    if (rstN && busDriveEn) begin
      if (!inCyc) begin
        inCyc = 1; cs = 0; ca = 0; ch = 0; glitch = 0;
        curByte = busData; curCmd = cmdLatch; curAddr = addrLatch;
      end
      if (busData !== curByte || cmdLatch !== curCmd || addrLatch !== curAddr) glitch = 1;
      if (!writeStrobeN) begin
        if (ch > 0) glitch = 1;
        ca++;
      end else if (ca == 0) cs++;
      else ch++;
    end else if (inCyc) begin
      inCyc = 0;
      endCycle();
    end else if (rstN && done) begin
      check(0, "R6", "done outside cycle end", 1, 0);
    end
  end

  // Watchdog
  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 50000, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(cmdLatch == 0 && addrLatch == 0, "R1", "latches in reset", int'({cmdLatch, addrLatch}), 0);
    check(writeStrobeN == 1, "R1", "strobe in reset", int'(writeStrobeN), 1);
    check(chipSelN == 1, "R1", "chip select in reset", int'(chipSelN), 1);
    check(busDriveEn == 0 && busy == 0 && done == 0, "R1", "idle in reset",
          int'({busDriveEn, busy, done}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(chipSelN == 1 && busDriveEn == 0, "R1", "idle after reset",
          int'({chipSelN, busDriveEn}), 2);

    // R8: disabled controller ignores start
    pulseStart(2'b01, 8'h11);
    repeat (10) @(negedge clk);
    check(busy == 0 && busDriveEn == 0, "R8", "start while disabled", int'({busy, busDriveEn}), 0);

    // Enable, chip select stays high (bit1=1)
    writeReg(1'b1, 8'b11);
    // R1: default maximum timings
    issue(2'b01, 8'h70, 3, 7, 7);
    waitIdle();

    // R9: chip select follows control bit 1
    writeReg(1'b1, 8'b01);
    check(chipSelN == 0, "R9", "chipSelN after writing 0", int'(chipSelN), 0);
    writeReg(1'b1, 8'b11);
    check(chipSelN == 1, "R9", "chipSelN after writing 1", int'(chipSelN), 1);
    writeReg(1'b1, 8'b01);

    // R10 layout / R2-R4 minimum lengths
    writeReg(1'b0, cfgWord(0, 0, 0));
    issue(2'b10, 8'hA5, 0, 0, 0);
    waitIdle();
    issue(2'b00, 8'h5A, 0, 0, 0);
    waitIdle();
    // R5: reserved kind acts as data
    issue(2'b11, 8'h3C, 0, 0, 0);
    waitIdle();

    // Mixed patterns
    writeReg(1'b0, cfgWord(1, 2, 3));
    issue(2'b01, 8'h90, 1, 2, 3);
    waitIdle();
    writeReg(1'b0, cfgWord(2, 0, 5));
    issue(2'b10, 8'h00, 2, 0, 5);
    waitIdle();
    writeReg(1'b0, cfgWord(3, 4, 1));
    issue(2'b00, 8'hFF, 3, 4, 1);
    waitIdle();

    // R10: timing write mid-cycle affects only the next cycle
    writeReg(1'b0, cfgWord(1, 1, 1));
    issue(2'b00, 8'hC3, 1, 1, 1);
    writeReg(1'b0, cfgWord(2, 3, 0));
    waitIdle();
    issue(2'b01, 8'h81, 2, 3, 0);
    waitIdle();

    // R7: start during a cycle is ignored
    writeReg(1'b0, cfgWord(2, 5, 4));
    issue(2'b10, 8'h42, 2, 5, 4);
    repeat (2) @(negedge clk);
    pulseStart(2'b01, 8'hEE);
    repeat (2) @(negedge clk);
    pulseStart(2'b00, 8'h99);
    waitIdle();
    repeat (8) @(negedge clk);
    check(busDriveEn == 0 && busy == 0, "R7", "no cycle after ignored start",
          int'({busDriveEn, busy}), 0);

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R7", "expected cycles outstanding", expQ.size(), 0);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule